// File: doc/BRIEF.md
# Transmit/Receive Front-End Control Sequencer

This block drives the parallel control lines of a dual-channel transmit/receive front end. For each channel it supplies an attenuator code, a phase-shifter code, a path switch (transmit or receive) and a receiver protector switch. It also supplies a sensitivity-time-control (STC) attenuation code, per-channel fast gain codes and the IF filter-bank select. All of these are timed against a single transmit gate input.

The switches are ordered around the gate. The protector closes before the path turns to transmit, and the path returns to receive before the protector opens. Beam codes are staged in shadow registers and take effect together at the start of a pulse.

After each pulse ends, the STC code walks through a loadable 64-entry table. It moves one entry every programmable number of clocks and then holds the last entry. The narrow or wide IF filter is chosen by comparing the commanded pulse width with a threshold. That choice is only re-evaluated while the gate is low.

Top module: `trx_ctrl_seq`

## Requirements
- R1: After reset, all code outputs, `path_tx`, `prot_on`, `filt_sel` and `stc_code` are zero. The table resets to all zeros.
- R2: `prot_on` (1 = engaged) goes high on the first clock edge that samples `tx_gate` high. `path_tx` (1 = transmit) goes high one edge later.
- R3: `path_tx` goes low on the first edge that samples `tx_gate` low. `prot_on` goes low one edge after that.
- R4: `path_tx` is never high on a channel whose `prot_on` is low.
- R5: A pulse on `beam_ld[c]` stores that channel's fields of `atten_in`/`phase_in` in a shadow. The outputs copy the shadow only on the edge that first samples `tx_gate` high. Channel c uses bits [6c+5:6c].
- R6: Call E0 the first edge that samples `tx_gate` low after it was high. n edges after E0, `stc_code` equals table entry min(63, floor(n/d)), where d = `stc_div`, and a value of 0 is treated as 1.
- R7: The STC code holds entry 63 until the next gate. From the edge that first samples the gate high until E0, it shows entry 0.
- R8: `filt_sel` (all bits equal, 1 = narrow) is loaded with (`pulse_width` > `pw_thresh`) on each edge that samples `tx_gate` low. It holds while the gate is high.
- R9: `agc_out` equals `agc_in` delayed by one clock. Channel c uses bits [6c+5:6c].
- R10: `tbl_wr` writes `tbl_data` to entry `tbl_addr`. The written value then appears on `stc_code` when that entry is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_gate | input | 1 | Transmit pulse gate |
| pulse_width | input | PW_W | Commanded pulse width |
| pw_thresh | input | PW_W | Narrow-filter threshold |
| stc_div | input | TICK_W | Clocks per STC table step (0 acts as 1) |
| beam_ld | input | NCH | Per-channel shadow load strobe |
| atten_in | input | NCH*CW | Staged attenuator codes |
| phase_in | input | NCH*CW | Staged phase codes |
| agc_in | input | NCH*CW | Fast gain codes |
| tbl_wr | input | 1 | STC table write strobe |
| tbl_addr | input | 6 | STC table write address |
| tbl_data | input | CW | STC table write data |
| atten_out | output | NCH*CW | Active attenuator codes |
| phase_out | output | NCH*CW | Active phase codes |
| path_tx | output | NCH | Path switch, 1 = transmit |
| prot_on | output | NCH | Receiver protector, 1 = engaged |
| stc_code | output | CW | STC attenuation code |
| agc_out | output | NCH*CW | Fast gain codes to the IF attenuators |
| filt_sel | output | NCH | IF filter select, 1 = narrow |

## Verification
The hardest state to reach from the ports is the hold at the final table entry. Reaching it takes 64 full step intervals after a trailing edge, with no gate rise in between. The stimulus therefore fills the whole table with distinct computed values first. It then sweeps the step divider over 0, 1, 2 and 3, and compares `stc_code` with the arithmetically expected entry on every clock of each tail, past the hold point. It also checks that the next gate returns the code to entry 0. A second hard case is a beam load that arrives during the gate: the bench loads new codes mid-pulse and confirms they stay hidden until the following rise.

// File: rtl/trx_seq_pkg.sv
package trx_seq_pkg;
  // Step divider with zero mapped to one.
  function automatic logic [31:0] eff_div(input logic [31:0] d);
    return (d == 32'd0) ? 32'd1 : d;
  endfunction

  // Narrow filter when the pulse is longer than the threshold.
  function automatic logic pick_narrow(input logic [31:0] pw, input logic [31:0] thr);
    return pw > thr;
  endfunction
endpackage

// File: rtl/trx_gate_seq.sv
module trx_gate_seq #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tx_gate,
  output logic           gate_rise,
  output logic           gate_fall,
  output logic [NCH-1:0] prot_on,
  output logic [NCH-1:0] path_tx
);
  logic g1, prot_q, path_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      g1     <= 1'b0;
      prot_q <= 1'b0;
      path_q <= 1'b0;
    end else begin
      g1     <= tx_gate;
      prot_q <= tx_gate | g1;
      path_q <= tx_gate & g1;
    end
  end

  assign gate_rise = tx_gate & ~g1;
  assign gate_fall = ~tx_gate & g1;
  assign prot_on   = {NCH{prot_q}};
  assign path_tx   = {NCH{path_q}};
endmodule

// File: rtl/trx_beam_buf.sv
module trx_beam_buf #(
  parameter int NCH = 2,
  parameter int CW  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gate_rise,
  input  logic [NCH-1:0]    beam_ld,
  input  logic [NCH*CW-1:0] atten_in,
  input  logic [NCH*CW-1:0] phase_in,
  output logic [NCH*CW-1:0] atten_out,
  output logic [NCH*CW-1:0] phase_out
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [CW-1:0] sh_att, sh_ph, act_att, act_ph;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sh_att  <= '0;
        sh_ph   <= '0;
        act_att <= '0;
        act_ph  <= '0;
      end else begin
        if (beam_ld[c]) begin
          sh_att <= atten_in[c*CW +: CW];
          sh_ph  <= phase_in[c*CW +: CW];
        end
        if (gate_rise) begin
          act_att <= sh_att;
          act_ph  <= sh_ph;
        end
      end
    end
    assign atten_out[c*CW +: CW] = act_att;
    assign phase_out[c*CW +: CW] = act_ph;
  end
endmodule

// File: rtl/trx_stc_gen.sv
module trx_stc_gen
  import trx_seq_pkg::*;
#(
  parameter int CW     = 6,
  parameter int DEPTH  = 64,
  parameter int TICK_W = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gate_rise,
  input  logic              gate_fall,
  input  logic [TICK_W-1:0] stc_div,
  input  logic              tbl_wr,
  input  logic [AW-1:0]     tbl_addr,
  input  logic [CW-1:0]     tbl_data,
  output logic [CW-1:0]     stc_code,
  output logic [AW-1:0]     stc_idx
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [CW-1:0]     tbl [DEPTH];
  logic [TICK_W-1:0] cnt;
  logic              run;
  logic [31:0]       div_e;
  logic              step_now;

  assign div_e    = eff_div(32'(stc_div));
  assign step_now = (32'(cnt) + 32'd1) >= div_e;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
    end else if (tbl_wr) begin
      tbl[tbl_addr] <= tbl_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stc_idx <= '0;
      cnt     <= '0;
      run     <= 1'b0;
    end else if (gate_rise) begin
      stc_idx <= '0;
      cnt     <= '0;
      run     <= 1'b0;
    end else if (gate_fall) begin
      stc_idx <= '0;
      cnt     <= '0;
      run     <= 1'b1;
    end else if (run) begin
      if (step_now) begin
        cnt <= '0;
        if (stc_idx == LAST) run <= 1'b0;
        else stc_idx <= stc_idx + 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign stc_code = tbl[stc_idx];
endmodule

// File: rtl/trx_ctrl_seq.sv
module trx_ctrl_seq
  import trx_seq_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int CW     = 6,
  parameter int DEPTH  = 64,
  parameter int TICK_W = 8,
  parameter int PW_W   = 12,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_gate,
  input  logic [PW_W-1:0]   pulse_width,
  input  logic [PW_W-1:0]   pw_thresh,
  input  logic [TICK_W-1:0] stc_div,
  input  logic [NCH-1:0]    beam_ld,
  input  logic [NCH*CW-1:0] atten_in,
  input  logic [NCH*CW-1:0] phase_in,
  input  logic [NCH*CW-1:0] agc_in,
  input  logic              tbl_wr,
  input  logic [AW-1:0]     tbl_addr,
  input  logic [CW-1:0]     tbl_data,
  output logic [NCH*CW-1:0] atten_out,
  output logic [NCH*CW-1:0] phase_out,
  output logic [NCH-1:0]    path_tx,
  output logic [NCH-1:0]    prot_on,
  output logic [CW-1:0]     stc_code,
  output logic [NCH*CW-1:0] agc_out,
  output logic [NCH-1:0]    filt_sel
);
  logic          gate_rise, gate_fall;
  logic [AW-1:0] stc_idx;
  logic          narrow_q;

  trx_gate_seq #(.NCH(NCH)) u_gate (
    .clk(clk), .rst_n(rst_n), .tx_gate(tx_gate),
    .gate_rise(gate_rise), .gate_fall(gate_fall),
    .prot_on(prot_on), .path_tx(path_tx)
  );

  trx_beam_buf #(.NCH(NCH), .CW(CW)) u_beam (
    .clk(clk), .rst_n(rst_n), .gate_rise(gate_rise), .beam_ld(beam_ld),
    .atten_in(atten_in), .phase_in(phase_in),
    .atten_out(atten_out), .phase_out(phase_out)
  );

  trx_stc_gen #(.CW(CW), .DEPTH(DEPTH), .TICK_W(TICK_W)) u_stc (
    .clk(clk), .rst_n(rst_n), .gate_rise(gate_rise), .gate_fall(gate_fall),
    .stc_div(stc_div), .tbl_wr(tbl_wr), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .stc_code(stc_code), .stc_idx(stc_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      narrow_q <= 1'b0;
      agc_out  <= '0;
    end else begin
      agc_out <= agc_in;
      if (!tx_gate) narrow_q <= pick_narrow(32'(pulse_width), 32'(pw_thresh));
    end
  end

  assign filt_sel = {NCH{narrow_q}};
endmodule

// File: rtl/trx_ctrl_seq_chk.sv
module trx_ctrl_seq_chk #(
  parameter int NCH = 2,
  parameter int CW  = 6,
  parameter int AW  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_gate,
  input logic              gate_rise,
  input logic [NCH-1:0]    prot_on,
  input logic [NCH-1:0]    path_tx,
  input logic [NCH*CW-1:0] atten_out,
  input logic [NCH*CW-1:0] phase_out,
  input logic [AW-1:0]     stc_idx,
  input logic [NCH-1:0]    filt_sel
);
  AST_PATH_AFTER_PROT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(path_tx[0]) |-> $past(prot_on[0])); // R2
  AST_PROT_AFTER_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prot_on[0]) |-> $past(!path_tx[0])); // R3
  AST_NO_TX_UNPROTECTED: assert property (@(posedge clk) disable iff (!rst_n)
    ((path_tx & ~prot_on) == '0)); // R4
  AST_BEAM_ONLY_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_rise |=> ($stable(atten_out) && $stable(phase_out))); // R5
  AST_STC_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (stc_idx != $past(stc_idx)) |-> ((stc_idx == AW'($past(stc_idx) + 1'b1)) || (stc_idx == '0))); // R6
  AST_FILT_HOLD_IN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_gate |=> $stable(filt_sel)); // R8
endmodule

bind trx_ctrl_seq trx_ctrl_seq_chk #(.NCH(NCH), .CW(CW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_gate(tx_gate), .gate_rise(gate_rise),
  .prot_on(prot_on), .path_tx(path_tx), .atten_out(atten_out),
  .phase_out(phase_out), .stc_idx(stc_idx), .filt_sel(filt_sel)
);

// File: tb/trx_ctrl_seq_tb.sv
module trx_ctrl_seq_tb;
  localparam int NCH = 2, CW = 6, DEPTH = 64, TICK_W = 8, PW_W = 12, AW = 6;

  logic clk = 1'b0, rst_n = 1'b0, tx_gate = 1'b0, tbl_wr = 1'b0;
  logic [PW_W-1:0] pulse_width = '0, pw_thresh = '0;
  logic [TICK_W-1:0] stc_div = '0;
  logic [NCH-1:0] beam_ld = '0;
  logic [NCH*CW-1:0] atten_in = '0, phase_in = '0, agc_in = '0;
  logic [AW-1:0] tbl_addr = '0;
  logic [CW-1:0] tbl_data = '0;
  logic [NCH*CW-1:0] atten_out, phase_out, agc_out;
  logic [NCH-1:0] path_tx, prot_on, filt_sel;
  logic [CW-1:0] stc_code;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  trx_ctrl_seq #(.NCH(NCH), .CW(CW), .DEPTH(DEPTH), .TICK_W(TICK_W), .PW_W(PW_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tx_gate(tx_gate), .pulse_width(pulse_width),
    .pw_thresh(pw_thresh), .stc_div(stc_div), .beam_ld(beam_ld),
    .atten_in(atten_in), .phase_in(phase_in), .agc_in(agc_in),
    .tbl_wr(tbl_wr), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .atten_out(atten_out), .phase_out(phase_out), .path_tx(path_tx),
    .prot_on(prot_on), .stc_code(stc_code), .agc_out(agc_out), .filt_sel(filt_sel)
  );

  function automatic int tval(input int i);
    return (i * 37 + 5) % 64;
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  localparam logic [11:0] ATT_A = {6'd9, 6'd17}, PH_A = {6'd40, 6'd3};
  localparam logic [11:0] ATT_B = {6'd50, 6'd21}, PH_B = {6'd7, 6'd63};

  task automatic run_stc(input int d);
    int de, n, e;
    de = (d == 0) ? 1 : d;
    stc_div = TICK_W'(d);
    tx_gate = 1'b1;
    step();
    chk(atten_out == ATT_B && phase_out == PH_B, "R5 mid-gate load applied at next rise", int'(atten_out), int'(ATT_B));
    chk((path_tx & ~prot_on) == '0, "R4 path without protector", int'(path_tx), 0);
    step(); step();
    chk(stc_code == CW'(tval(0)), "R7 entry 0 during gate", int'(stc_code), tval(0));
    tx_gate = 1'b0;
    step();
    for (n = 0; n <= 64 * de + 3; n++) begin
      e = n / de;
      if (e > 63) e = 63;
      chk(stc_code == CW'(tval(e)), $sformatf("R6 stc step d=%0d n=%0d", d, n), int'(stc_code), tval(e));
      step();
    end
    repeat (5) step();
    chk(stc_code == CW'(tval(63)), "R7 hold last entry", int'(stc_code), tval(63));
    tx_gate = 1'b1;
    step();
    chk(stc_code == CW'(tval(0)), "R7 back to entry 0 at gate", int'(stc_code), tval(0));
    tx_gate = 1'b0;
    step(); step();
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    // R1 reset state
    chk(prot_on == 0 && path_tx == 0, "R1 switches reset", int'({prot_on, path_tx}), 0);
    chk(atten_out == 0 && phase_out == 0, "R1 beam codes reset", int'(atten_out), 0);
    chk(stc_code == 0 && filt_sel == 0 && agc_out == 0, "R1 stc/filter/agc reset", int'(stc_code), 0);

    // R10 table load
    for (int i = 0; i < 64; i++) begin
      tbl_wr = 1'b1; tbl_addr = AW'(i); tbl_data = CW'(tval(i));
      step();
    end
    tbl_wr = 1'b0;
    chk(stc_code == CW'(tval(0)), "R10 entry 0 written", int'(stc_code), tval(0));

    // R5 staging while idle
    beam_ld = 2'b11; atten_in = ATT_A; phase_in = PH_A;
    step();
    beam_ld = 2'b00;
    step();
    chk(atten_out == 0 && phase_out == 0, "R5 staged codes hidden before rise", int'(atten_out), 0);

    // R2 gate rise ordering
    tx_gate = 1'b1;
    step();
    chk(prot_on == 2'b11 && path_tx == 2'b00, "R2 protector first", int'({prot_on, path_tx}), 12);
    chk(atten_out == ATT_A && phase_out == PH_A, "R5 codes applied at rise", int'(atten_out), int'(ATT_A));
    step();
    chk(prot_on == 2'b11 && path_tx == 2'b11, "R2 path to transmit", int'({prot_on, path_tx}), 15);
    chk((path_tx & ~prot_on) == '0, "R4 path without protector", int'(path_tx), 0);
    beam_ld = 2'b11; atten_in = ATT_B; phase_in = PH_B;
    step();
    beam_ld = 2'b00;
    step();
    chk(atten_out == ATT_A && phase_out == PH_A, "R5 mid-gate load hidden", int'(atten_out), int'(ATT_A));

    // R3 gate fall ordering
    tx_gate = 1'b0;
    step();
    chk(prot_on == 2'b11 && path_tx == 2'b00, "R3 path back first", int'({prot_on, path_tx}), 12);
    step();
    chk(prot_on == 2'b00 && path_tx == 2'b00, "R3 protector released", int'({prot_on, path_tx}), 0);
    chk(atten_out == ATT_A, "R5 codes held after gate", int'(atten_out), int'(ATT_A));

    // R6 R7 sweep of step divider
    for (int d = 0; d < 4; d++) run_stc(d);

    // R8 filter select
    pw_thresh = 12'd10;
    for (int pw = 0; pw <= 20; pw++) begin
      pulse_width = PW_W'(pw);
      step();
      chk(filt_sel == ((pw > 10) ? 2'b11 : 2'b00), $sformatf("R8 filter pw=%0d", pw), int'(filt_sel), (pw > 10) ? 3 : 0);
    end
    tx_gate = 1'b1; pulse_width = '0;
    step(); step();
    chk(filt_sel == 2'b11, "R8 filter held during gate", int'(filt_sel), 3);
    tx_gate = 1'b0;
    step();
    chk(filt_sel == 2'b00, "R8 filter relatched after gate", int'(filt_sel), 0);

    // R9 fast gain passthrough
    for (int v = 0; v < 64; v += 9) begin
      agc_in = {6'(v), 6'(v ^ 42)};
      step();
      chk(agc_out == {6'(v), 6'(v ^ 42)}, "R9 agc delay", int'(agc_out), int'({6'(v), 6'(v ^ 42)}));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule